// File: doc/BRIEF.md
# Iterative Add-Rotate-XOR Hash Round Core

This block holds a 1024-bit hash state as thirty-two 32-bit words and advances it with one add-rotate-XOR round per clock cycle. A set-up strobe loads the state from three configuration values: the digest length in bytes, the block size in bytes and the round count. It then mixes that state through a long warm-up run. Each accepted message byte is XORed into the state and followed by a short run of rounds. A close strobe flips bit 0 of the last word and runs the long run again. At the end of that run the leading digest bits of the state are captured into a held output register.

Padding and byte ordering of the message happen outside the block. With the default configuration, a block takes 8 round cycles and the warm-up and close runs take 80 cycles each. The controller has four phases. `ST_IDLE` waits for a strobe. `ST_SETUP` runs the warm-up after a set-up strobe. `ST_ABSORB` runs the per-block rounds after a message byte. `ST_CLOSE` runs the closing rounds after a close strobe. Each run phase goes back to `ST_IDLE` when its round counter reaches its last value. The transitions out of `ST_IDLE` are set-up, close and absorb, taken in that order of priority.

Top module: `arxh_core`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and `digest_o` is all zeros.
- R2: A set-up strobe taken in idle loads word 0 with DIGEST_BITS/8, word 1 with BLOCK_BYTES and word 2 with ROUNDS, and clears every other word. It then applies INIT_MULT·ROUNDS rounds with `busy_o` high for exactly that many cycles, and `done_o` stays low throughout.
- R3: A message byte taken in idle is XORed into state byte 0. State byte k is bits 8(k mod 4)+7..8(k mod 4) of word k/4 (little-endian). ROUNDS rounds then follow with `busy_o` high for exactly ROUNDS cycles, and `done_o` is high in the cycle after the last round.
- R4: One round does two half-steps, each applied to the low half L (words 0..15) and the high half H (words 16..31). In the first half-step, H[i] += L[i] mod 2^32, L[i] is rotated left by 7, L[i] takes L[i^8], L[i] ^= H[i], and H[i] takes H[i^2]. The second half-step is the same with rotation 11, L index mask 4 and H index mask 1.
- R5: A close strobe taken in idle XORs 1 into word 31 and applies INIT_MULT·ROUNDS rounds. `done_o` then pulses, and `digest_o` takes the first DIGEST_BITS bits of the state, with bits 32k+31..32k holding word k.
- R6: Set-up, close and message strobes that arrive while `busy_o` is high are ignored.
- R7: `digest_o` changes only when a close run completes or when a set-up strobe is taken, and a set-up strobe clears it to zero.
- R8: When several strobes arrive together in idle, set-up wins over close, and close wins over a message byte. The strobes that lose have no effect.
- R9: `done_o` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_i | input | 1 | Set-up strobe |
| final_i | input | 1 | Close strobe |
| msg_valid_i | input | 1 | Message byte valid |
| msg_i | input | 8·BLOCK_BYTES | Message block |
| busy_o | output | 1 | A run of rounds is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a block or close run |
| digest_o | output | DIGEST_BITS | Held digest |

## Verification
The bench sweeps all 256 one-byte messages through set-up, absorb and close, and compares the full digest against a round model written in the bench. That comparison catches a wrong rotation, a wrong swap mask, a wrong addition direction or a misplaced XOR of the message or the close bit. Every run is timed, so a counter that is off by one shows up as a wrong busy length and also as a wrong digest. The bench injects strobes during a busy run and raises colliding strobes in idle. A core that restarts or absorbs mid-run, or that breaks the strobe priority, produces a digest or run length that differs from the model. The bench also checks that the digest holds across later message blocks and clears on set-up, which catches a design that exposes the live state as the digest.

// File: rtl/arxh_pkg.sv
package arxh_pkg;

    localparam int WORD_W  = 32;
    localparam int N_WORDS = 32;
    localparam int HALF    = N_WORDS / 2;
    localparam int STATE_W = WORD_W * N_WORDS;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [N_WORDS-1:0] state_t;
    typedef word_t [HALF-1:0] half_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ABSORB,
        ST_CLOSE
    } phase_e;

endpackage

// File: rtl/arxh_half.sv
module arxh_half
    import arxh_pkg::*;
#(
    parameter int ROT     = 7,
    parameter int LO_MASK = 8,
    parameter int HI_MASK = 2
) (
    input  half_t lo_i,
    input  half_t hi_i,
    output half_t lo_o,
    output half_t hi_o
);

    half_t hi_sum;
    half_t lo_rot;
    half_t lo_mix;

    // add low into high, rotate low, then cross and fold with rewired indices
    for (genvar g = 0; g < HALF; g++) begin : g_lane
        assign hi_sum[g] = hi_i[g] + lo_i[g];
        assign lo_rot[g] = {lo_i[g][WORD_W-1-ROT:0], lo_i[g][WORD_W-1:WORD_W-ROT]};
    end

    for (genvar g = 0; g < HALF; g++) begin : g_cross
        assign lo_mix[g] = lo_rot[g ^ LO_MASK] ^ hi_sum[g];
        assign hi_o[g]   = hi_sum[g ^ HI_MASK];
    end

    assign lo_o = lo_mix;

endmodule

// File: rtl/arxh_round.sv
module arxh_round
    import arxh_pkg::*;
(
    input  state_t x_i,
    output state_t x_o
);

    half_t lo_a, hi_a, lo_b, hi_b, lo_c, hi_c;

    for (genvar g = 0; g < HALF; g++) begin : g_split
        assign lo_a[g]      = x_i[g];
        assign hi_a[g]      = x_i[g + HALF];
        assign x_o[g]       = lo_c[g];
        assign x_o[g + HALF] = hi_c[g];
    end

    arxh_half #(.ROT(7), .LO_MASK(8), .HI_MASK(2)) u_first (
        .lo_i(lo_a), .hi_i(hi_a), .lo_o(lo_b), .hi_o(hi_b)
    );

    arxh_half #(.ROT(11), .LO_MASK(4), .HI_MASK(1)) u_second (
        .lo_i(lo_b), .hi_i(hi_b), .lo_o(lo_c), .hi_o(hi_c)
    );

endmodule

// File: rtl/arxh_ctrl.sv
module arxh_ctrl
    import arxh_pkg::*;
#(
    parameter int ROUNDS    = 8,
    parameter int INIT_MULT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic final_i,
    input  logic msg_valid_i,
    output logic load_o,
    output logic absorb_o,
    output logic close_o,
    output logic step_o,
    output logic capture_o,
    output logic busy_o,
    output logic done_o
);

    localparam int LONG_RUN = ROUNDS * INIT_MULT;
    localparam int CNT_W    = $clog2(LONG_RUN + 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(ROUNDS - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_RUN - 1);

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_q, done_d;
    logic             last;
    logic             idle;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    // outputs and strobe decode
    always_comb begin
        idle      = (phase_q == ST_IDLE);
        load_o    = idle && init_i;
        close_o   = idle && !init_i && final_i;
        absorb_o  = idle && !init_i && !final_i && msg_valid_i;
        step_o    = !idle;
        last      = 1'b0;
        unique case (phase_q)
            ST_IDLE:   last = 1'b0;
            ST_ABSORB: last = (cnt_q == SHORT_LAST);
            ST_SETUP,
            ST_CLOSE:  last = (cnt_q == LONG_LAST);
        endcase
        capture_o = last && (phase_q == ST_CLOSE);
        done_d    = last && (phase_q != ST_SETUP);
        busy_o    = !idle;
        done_o    = done_q;
    end

    // next phase
    always_comb begin
        phase_d = phase_q;
        cnt_d   = '0;
        unique case (phase_q)
            ST_IDLE: begin
                if (load_o)        phase_d = ST_SETUP;
                else if (close_o)  phase_d = ST_CLOSE;
                else if (absorb_o) phase_d = ST_ABSORB;
            end
            ST_SETUP, ST_ABSORB, ST_CLOSE: begin
                if (last) phase_d = ST_IDLE;
                else      cnt_d   = cnt_q + 1'b1;
            end
        endcase
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    a_r6_run_uninterrupted: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != ST_IDLE) |=> (phase_q == ST_IDLE) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    a_r3_block_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == ST_ABSORB) |-> (cnt_q < CNT_W'(ROUNDS)));

    a_r2_setup_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == ST_SETUP) |=> !done_q);

    a_r8_setup_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == ST_IDLE && init_i) |=> (phase_q == ST_SETUP));

endmodule

// File: rtl/arxh_core.sv
module arxh_core
    import arxh_pkg::*;
#(
    parameter int DIGEST_BITS = 512,
    parameter int BLOCK_BYTES = 1,
    parameter int ROUNDS      = 8,
    parameter int INIT_MULT   = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init_i,
    input  logic                     final_i,
    input  logic                     msg_valid_i,
    input  logic [8*BLOCK_BYTES-1:0] msg_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [DIGEST_BITS-1:0]   digest_o
);

    localparam int MSG_W = 8 * BLOCK_BYTES;

    state_t                 state_q;
    state_t                 round_out;
    state_t                 seed;
    state_t                 close_mask;
    logic [STATE_W-1:0]     round_flat;
    logic [DIGEST_BITS-1:0] digest_q;
    logic load, absorb, close, step, capture;

    always_comb begin
        seed       = '0;
        seed[0]    = WORD_W'(DIGEST_BITS / 8);
        seed[1]    = WORD_W'(BLOCK_BYTES);
        seed[2]    = WORD_W'(ROUNDS);
        close_mask = '0;
        close_mask[N_WORDS-1] = WORD_W'(1);
    end

    arxh_ctrl #(.ROUNDS(ROUNDS), .INIT_MULT(INIT_MULT)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .init_i(init_i), .final_i(final_i), .msg_valid_i(msg_valid_i),
        .load_o(load), .absorb_o(absorb), .close_o(close),
        .step_o(step), .capture_o(capture),
        .busy_o(busy_o), .done_o(done_o)
    );

    arxh_round u_round (.x_i(state_q), .x_o(round_out));

    assign round_flat = round_out;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (load) begin
            state_q <= seed;
        end else if (absorb) begin
            state_q <= state_q ^ state_t'({{(STATE_W-MSG_W){1'b0}}, msg_i});
        end else if (close) begin
            state_q <= state_q ^ close_mask;
        end else if (step) begin
            state_q <= round_out;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       digest_q <= '0;
        else if (load)    digest_q <= '0;
        else if (capture) digest_q <= round_flat[DIGEST_BITS-1:0];
    end

    assign digest_o = digest_q;

    a_r7_digest_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !capture) |=> $stable(digest_q));

    a_r7_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (digest_q == '0));

    a_r6_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(load || absorb || close));

endmodule

// File: tb/tb_arxh_core.sv
`timescale 1ns/1ps
module tb_arxh_core;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_i = 1'b0, final_i = 1'b0, msg_valid_i = 1'b0;
    logic [7:0]   msg_i = '0;
    logic         busy_o, done_o;
    logic [511:0] digest_o;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;
    logic [31:0] mx [32];

    always #2.5 clk = ~clk;

    arxh_core dut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .final_i(final_i),
        .msg_valid_i(msg_valid_i), .msg_i(msg_i),
        .busy_o(busy_o), .done_o(done_o), .digest_o(digest_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] rl(logic [31:0] w, int n);
        return (w << n) | (w >> (32 - n));
    endfunction

    task automatic swp(int a, int b);
        logic [31:0] t; t = mx[a]; mx[a] = mx[b]; mx[b] = t;
    endtask

    task automatic m_round();
        for (int i = 0; i < 16; i++) mx[i+16] = mx[i+16] + mx[i];
        for (int i = 0; i < 16; i++) mx[i] = rl(mx[i], 7);
        for (int i = 0; i < 8; i++) swp(i, i + 8);
        for (int i = 0; i < 16; i++) mx[i] = mx[i] ^ mx[i+16];
        for (int i = 16; i < 32; i++) if ((i & 2) == 0) swp(i, i + 2);
        for (int i = 0; i < 16; i++) mx[i+16] = mx[i+16] + mx[i];
        for (int i = 0; i < 16; i++) mx[i] = rl(mx[i], 11);
        for (int i = 0; i < 16; i++) if ((i & 4) == 0) swp(i, i + 4);
        for (int i = 0; i < 16; i++) mx[i] = mx[i] ^ mx[i+16];
        for (int i = 16; i < 32; i += 2) swp(i, i + 1);
    endtask

    task automatic m_init();
        for (int i = 0; i < 32; i++) mx[i] = 32'd0;
        mx[0] = 32'd64; mx[1] = 32'd1; mx[2] = 32'd8;
        repeat (80) m_round();
    endtask

    task automatic m_absorb(logic [7:0] v);
        mx[0][7:0] = mx[0][7:0] ^ v;
        repeat (8) m_round();
    endtask

    task automatic m_close();
        mx[31] = mx[31] ^ 32'd1;
        repeat (80) m_round();
    endtask

    function automatic logic [511:0] m_digest();
        logic [511:0] e;
        for (int k = 0; k < 16; k++) e[32*k +: 32] = mx[k];
        return e;
    endfunction

    task automatic chk(string req, string what, logic [511:0] act, logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse(bit ini, bit fin, bit vld, logic [7:0] v);
        init_i = ini; final_i = fin; msg_valid_i = vld; msg_i = v;
        @(negedge clk);
        init_i = 0; final_i = 0; msg_valid_i = 0; msg_i = '0;
    endtask

    task automatic wait_idle(inout int n, output int dones);
        dones = 0;
        while (busy_o && n < 2000) begin
            n++;
            if (done_o) dones++;
            @(negedge clk);
        end
    endtask

    task automatic do_setup(bit fin, bit vld);
        int n, d;
        n = 0;
        pulse(1, fin, vld, 8'h5a);
        wait_idle(n, d);
        chk("R2", "setup run length", 512'(n), 512'd80);
        chk("R2", "no done during setup", 512'(d + done_o), 512'd0);
        chk("R7", "setup clears digest", digest_o, 512'd0);
        m_init();
    endtask

    task automatic do_msg(logic [7:0] v);
        int n, d;
        n = 0;
        pulse(0, 0, 1, v);
        wait_idle(n, d);
        chk("R3", "block run length", 512'(n), 512'd8);
        chk("R3", "done after block", 512'(done_o), 512'd1);
        @(negedge clk);
        chk("R9", "done one cycle", 512'(done_o), 512'd0);
        m_absorb(v);
    endtask

    task automatic do_close(bit vld);
        int n, d;
        n = 0;
        pulse(0, 1, vld, 8'hc3);
        wait_idle(n, d);
        chk("R5", "close run length", 512'(n), 512'd80);
        chk("R5", "done after close", 512'(done_o), 512'd1);
        @(negedge clk);
        chk("R9", "done one cycle", 512'(done_o), 512'd0);
        m_close();
        chk("R4", "digest matches round model", digest_o, m_digest());
    endtask

    initial begin
        logic [511:0] held;
        int n, d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", 512'(busy_o), 512'd0);
        chk("R1", "done after reset", 512'(done_o), 512'd0);
        chk("R1", "digest after reset", digest_o, 512'd0);

        // R3 R5: sweep of every one-byte message
        for (int v = 0; v < 256; v++) begin
            do_setup(0, 0);
            do_msg(8'(v));
            do_close(0);
        end

        // R3: several blocks
        do_setup(0, 0);
        do_msg(8'h61); do_msg(8'h62); do_msg(8'h63);
        do_close(0);

        // R7: digest held across later blocks
        held = digest_o;
        do_msg(8'h33);
        chk("R7", "digest held after block", digest_o, held);

        // R6: strobes while busy are ignored
        do_setup(0, 0);
        pulse(0, 0, 1, 8'h61);
        init_i = 1; final_i = 1; msg_valid_i = 1; msg_i = 8'h62;
        @(negedge clk);
        init_i = 0; final_i = 0; msg_valid_i = 0; msg_i = '0;
        n = 1;
        wait_idle(n, d);
        chk("R6", "busy strobes do not extend block", 512'(n), 512'd8);
        @(negedge clk);
        m_absorb(8'h61);
        do_close(0);

        // R8: set-up beats close and message; close beats message
        do_setup(1, 1);
        do_close(1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule